// File: doc/BRIEF.md
# I2C Write-Only Target with Sequenced Status Flags

This block is a bus target that accepts write transfers from an I2C controller and hands the received bytes to software through a small register window. It samples the clock and data lines through synchronizers and pulls either line low through open-drain style enables. It recognises START and STOP on the bus, compares the first byte (or the first two bytes in 10-bit mode) with a programmed own address, and acknowledges the address and every data byte.

Software learns what is happening from three status flags: address matched, receive byte waiting, and STOP seen. The address-matched and STOP flags each clear only through an ordered pair of register accesses. While the address-matched flag is set, the block stretches the bus clock, so software has time to prepare before any data arrives. If a data byte completes while the previous one is still unread, the clock is stretched again, before the acknowledge, until software reads the waiting byte.

Top module: `i2c_rx_target`

## Requirements
- R1: After reset all status flags read 0, the control and own-address registers read 0, and neither line is pulled low.
- R2: With the block enabled in 7-bit mode, a byte after START whose upper 7 bits equal the own address and whose bit 0 (direction) is 0 is acknowledged (SDA low during the 9th clock), sets the address flag (status-1 bit 0), and the block then holds SCL low once the 9th clock has fallen.
- R3: The address flag clears, and SCL is released, only when a read of status register 2 (offset 3) directly follows a read of status register 1 (offset 2) made while the flag was set; any other access in between, or a status-2 read alone, leaves the flag and the stretch in place.
- R4: Each data byte after a matched address is acknowledged, appears in the data register (offset 4, bits 7:0, first bus bit in bit 7), and sets the buffer-full flag (status-1 bit 1); a read of the data register clears that flag.
- R5: When a byte completes while the buffer-full flag is still set, the block holds SCL low after the 8th bit without acknowledging; once the data register is read it loads the new byte, drives the acknowledge and releases SCL.
- R6: A STOP after this target was addressed sets the stop flag (status-1 bit 2); it clears only when a write to the control register (offset 0) directly follows a status-1 read made while the flag was set, and any other access in between leaves it set.
- R7: In 10-bit mode (control bit 1) the block acknowledges a first byte of the form 11110, own address bits 9:8, direction 0, then sets the address flag only after a second byte equal to own address bits 7:0, which it also acknowledges.
- R8: A mismatching address byte (wrong address, direction 1, wrong 10-bit header or wrong low byte) is not acknowledged, sets no flag, and the block ignores further bytes until the next START.
- R9: A repeated START restarts address matching and does not set the stop flag.
- R10: The block changes its SDA drive only while SCL is low.
- R11: The own address register (offset 1, bits 9:0) and control register (bit 0 enable, bit 1 10-bit mode) read back what was written; status 2 bit 0 shows that the bus is between a START and a STOP.
- R12: With control bit 0 clear, bus traffic is not acknowledged and sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sclOutLow | output | 1 | Pull bus clock low (stretch) |
| sdaOutLow | output | 1 | Pull bus data low (acknowledge) |
| regAddr | input | REG_AW | Register offset |
| regRd | input | 1 | Read strobe, one cycle per access |
| regWr | input | 1 | Write strobe, one cycle per access |
| regWdata | input | REG_DW | Write data |
| regRdata | output | REG_DW | Read data, valid while regRd is high |

## Verification
A wrong transfer state shows up on the bus within one bit time: a missing or misplaced acknowledge is seen by the controller at the 9th clock, and a stretch that never starts or never ends appears as SCL moving when it should be held, or the controller stalling. A flag clear sequence that is too lenient or too strict shows at the next status-1 read and, for the address flag, as SCL released or held at the wrong moment. A data path error shows as a wrong byte on the very next data register read, and a lost byte under back-pressure shows as the wrong value on the read after the stretched acknowledge.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned OWN_W = 10;

  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_OWN   = 1;
  localparam int unsigned OFS_STAT1 = 2;
  localparam int unsigned OFS_STAT2 = 3;
  localparam int unsigned OFS_DATA  = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACK, ST_HOLD, ST_WAITBUF
  } rxState_t;

  typedef enum logic [1:0] {
    K_ADDR1, K_ADDR2, K_DATA
  } byteKind_t;

  typedef struct packed {
    logic clrBits;
    logic loadData;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_rx_dpath.sv
module i2c_rx_dpath
  import i2c_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  input  logic [OWN_W-1:0]     ownAddr,
  input  dpStrobe_t            strobe,
  output logic                 sclSync,
  output logic                 sclFall,
  output logic                 startDet,
  output logic                 stopDet,
  output logic                 byteDone,
  output logic                 hit7,
  output logic                 hitHdr,
  output logic                 hitLow,
  output logic [BYTE_BITS-1:0] dataByte
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1) + 1;

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sdaSync, sclPrev, sdaPrev, sclRise;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_BITS-1:0] shiftReg;

  assign sclSync = sclPipe[SYNC_STAGES-1];
  assign sdaSync = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclSync & ~sclPrev;
  assign sclFall = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;
  assign byteDone = (bitCnt == CNT_W'(BYTE_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt   <= '0;
      shiftReg <= '0;
      dataByte <= '0;
    end else begin
      if (strobe.clrBits) begin
        bitCnt <= '0;
      end else if (sclRise && bitCnt != '1) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (sclRise && bitCnt < CNT_W'(BYTE_BITS)) begin
        shiftReg <= {shiftReg[BYTE_BITS-2:0], sdaSync};
      end
      if (strobe.loadData) begin
        dataByte <= shiftReg;
      end
    end
  end

  assign hit7   = (shiftReg[7:1] == ownAddr[6:0]) && !shiftReg[0];
  assign hitHdr = (shiftReg[7:3] == 5'b11110) && (shiftReg[2:1] == ownAddr[9:8]) && !shiftReg[0];
  assign hitLow = (shiftReg == ownAddr[7:0]);
endmodule

// File: rtl/i2c_rx_ctrl.sv
module i2c_rx_ctrl
  import i2c_rx_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int REG_DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [REG_DW-1:0]    regWdata,
  output logic [REG_DW-1:0]    regRdata,
  input  logic                 sclFall,
  input  logic                 startDet,
  input  logic                 stopDet,
  input  logic                 byteDone,
  input  logic                 hit7,
  input  logic                 hitHdr,
  input  logic                 hitLow,
  input  logic [BYTE_BITS-1:0] dataByte,
  output dpStrobe_t            strobe,
  output logic [OWN_W-1:0]     ownAddr,
  output logic                 sclOutLow,
  output logic                 sdaOutLow,
  output logic                 addrHit,
  output logic                 rxFull,
  output logic                 stopFlag
);
  rxState_t  st, stN;
  byteKind_t kind, kindN;
  logic sdaLow, sdaLowN, toHold, toHoldN, selected, selN;
  logic setHit, setFull, setStop;
  logic enable, tenBit, busy, armHit, armStop;
  logic anyAcc, rdStat1, rdStat2, rdData, wrCtrl, wrOwn;
  logic unusedWdata;

  assign anyAcc  = regRd | regWr;
  assign rdStat1 = regRd && regAddr == REG_AW'(OFS_STAT1);
  assign rdStat2 = regRd && regAddr == REG_AW'(OFS_STAT2);
  assign rdData  = regRd && regAddr == REG_AW'(OFS_DATA);
  assign wrCtrl  = regWr && regAddr == REG_AW'(OFS_CTRL);
  assign wrOwn   = regWr && regAddr == REG_AW'(OFS_OWN);
  assign unusedWdata = ^regWdata[REG_DW-1:OWN_W];

  always_comb begin
    stN = st; kindN = kind; sdaLowN = sdaLow; toHoldN = toHold; selN = selected;
    setHit = 1'b0; setFull = 1'b0; setStop = 1'b0; strobe = '0;
    if (startDet && enable) begin
      stN = ST_RECV; kindN = K_ADDR1; sdaLowN = 1'b0; selN = 1'b0; strobe.clrBits = 1'b1;
    end else if (stopDet) begin
      stN = ST_IDLE; sdaLowN = 1'b0; selN = 1'b0; setStop = selected;
    end else begin
      case (st)
        ST_RECV: if (sclFall && byteDone) begin
          if (kind == K_DATA) begin
            if (rxFull) stN = ST_WAITBUF;
            else begin
              strobe.loadData = 1'b1; setFull = 1'b1; sdaLowN = 1'b1; toHoldN = 1'b0; stN = ST_ACK;
            end
          end else if (kind == K_ADDR1 && tenBit) begin
            if (hitHdr) begin
              sdaLowN = 1'b1; toHoldN = 1'b0; kindN = K_ADDR2; stN = ST_ACK;
            end else stN = ST_IDLE;
          end else if ((kind == K_ADDR1 && hit7) || (kind == K_ADDR2 && hitLow)) begin
            sdaLowN = 1'b1; toHoldN = 1'b1; kindN = K_DATA; setHit = 1'b1; selN = 1'b1; stN = ST_ACK;
          end else stN = ST_IDLE;
        end
        ST_ACK: if (sclFall) begin
          sdaLowN = 1'b0; strobe.clrBits = 1'b1; stN = toHold ? ST_HOLD : ST_RECV;
        end
        ST_HOLD: if (!addrHit) stN = ST_RECV;
        ST_WAITBUF: if (!rxFull) begin
          strobe.loadData = 1'b1; setFull = 1'b1; sdaLowN = 1'b1; toHoldN = 1'b0; stN = ST_ACK;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; kind <= K_ADDR1; sdaLow <= 1'b0; toHold <= 1'b0; selected <= 1'b0;
      addrHit <= 1'b0; rxFull <= 1'b0; stopFlag <= 1'b0; armHit <= 1'b0; armStop <= 1'b0;
      enable <= 1'b0; tenBit <= 1'b0; ownAddr <= '0; busy <= 1'b0;
    end else begin
      st <= stN; kind <= kindN; sdaLow <= sdaLowN; toHold <= toHoldN; selected <= selN;
      if (anyAcc) begin
        armHit  <= rdStat1 && addrHit;
        armStop <= rdStat1 && stopFlag;
      end
      if (setHit) addrHit <= 1'b1;
      else if (rdStat2 && armHit) addrHit <= 1'b0;
      if (setFull) rxFull <= 1'b1;
      else if (rdData) rxFull <= 1'b0;
      if (setStop) stopFlag <= 1'b1;
      else if (wrCtrl && armStop) stopFlag <= 1'b0;
      if (startDet) busy <= 1'b1;
      else if (stopDet) busy <= 1'b0;
      if (wrCtrl) begin
        enable <= regWdata[0];
        tenBit <= regWdata[1];
      end
      if (wrOwn) ownAddr <= regWdata[OWN_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == REG_AW'(OFS_CTRL)) regRdata[1:0] = {tenBit, enable};
    else if (regAddr == REG_AW'(OFS_OWN)) regRdata[OWN_W-1:0] = ownAddr;
    else if (regAddr == REG_AW'(OFS_STAT1)) regRdata[2:0] = {stopFlag, rxFull, addrHit};
    else if (regAddr == REG_AW'(OFS_STAT2)) regRdata[0] = busy;
    else if (regAddr == REG_AW'(OFS_DATA)) regRdata[BYTE_BITS-1:0] = dataByte;
  end

  assign sclOutLow = (st == ST_HOLD) || (st == ST_WAITBUF);
  assign sdaOutLow = sdaLow;
endmodule

// File: rtl/i2c_rx_target.sv
module i2c_rx_target
  import i2c_rx_pkg::*;
#(
  parameter int REG_AW = 3,
  parameter int REG_DW = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOutLow,
  output logic              sdaOutLow,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [REG_DW-1:0] regWdata,
  output logic [REG_DW-1:0] regRdata
);
  dpStrobe_t strobe;
  logic [OWN_W-1:0] ownAddr;
  logic [BYTE_BITS-1:0] dataByte;
  logic sclSync, sclFall, startDet, stopDet, byteDone, hit7, hitHdr, hitLow;
  logic addrHit, rxFull, stopFlag;

  i2c_rx_dpath #(.SYNC_STAGES(SYNC_STAGES)) dpath_i (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn), .ownAddr(ownAddr),
    .strobe(strobe), .sclSync(sclSync), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .byteDone(byteDone), .hit7(hit7), .hitHdr(hitHdr),
    .hitLow(hitLow), .dataByte(dataByte)
  );

  i2c_rx_ctrl #(.REG_AW(REG_AW), .REG_DW(REG_DW)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
    .regWdata(regWdata), .regRdata(regRdata), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .byteDone(byteDone), .hit7(hit7), .hitHdr(hitHdr),
    .hitLow(hitLow), .dataByte(dataByte), .strobe(strobe), .ownAddr(ownAddr),
    .sclOutLow(sclOutLow), .sdaOutLow(sdaOutLow), .addrHit(addrHit),
    .rxFull(rxFull), .stopFlag(stopFlag)
  );
endmodule

// File: rtl/i2c_rx_checker.sv
module i2c_rx_checker
  import i2c_rx_pkg::*;
#(
  parameter int REG_AW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [REG_AW-1:0] regAddr,
  input logic              regRd,
  input logic              regWr,
  input logic              sclOutLow,
  input logic              sdaOutLow,
  input logic              sclSync,
  input logic              stopDet,
  input logic              addrHit,
  input logic              rxFull,
  input logic              stopFlag
);
  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sdaOutLow != $past(sdaOutLow)) |-> !sclSync);

  assert_hit_clear_stat2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addrHit) |-> $past(regRd && regAddr == REG_AW'(OFS_STAT2)));

  assert_full_clear_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rxFull) |-> $past(regRd && regAddr == REG_AW'(OFS_DATA)));

  assert_stop_from_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopFlag) |-> $past(stopDet));

  assert_stop_clear_ctrl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stopFlag) |-> $past(regWr && regAddr == REG_AW'(OFS_CTRL)));

  assert_stretch_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclOutLow && !addrHit && !rxFull) |=> !sclOutLow);
endmodule

bind i2c_rx_target i2c_rx_checker #(.REG_AW(REG_AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .regAddr(regAddr), .regRd(regRd), .regWr(regWr),
  .sclOutLow(sclOutLow), .sdaOutLow(sdaOutLow), .sclSync(sclSync),
  .stopDet(stopDet), .addrHit(addrHit), .rxFull(rxFull), .stopFlag(stopFlag)
);

// File: tb/i2c_rx_target_tb_top.sv
module i2c_rx_target_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam logic [AW-1:0] A_CTRL = 0, A_OWN = 1, A_ST1 = 2, A_ST2 = 3, A_DATA = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1;
  logic sclLine, sdaLine;
  logic sclOutLow, sdaOutLow;
  logic [AW-1:0] regAddr = '0;
  logic regRd = 1'b0, regWr = 1'b0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  int checks = 0, errors = 0, sdaViol = 0;
  logic sdaPrev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sclLine = sclDrv & ~sclOutLow;
  assign sdaLine = sdaDrv & ~sdaOutLow;

  i2c_rx_target #(.REG_AW(AW), .REG_DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOutLow(sclOutLow), .sdaOutLow(sdaOutLow), .regAddr(regAddr),
    .regRd(regRd), .regWr(regWr), .regWdata(regWdata), .regRdata(regRdata)
  );

  always @(negedge clk) begin
    if (rst_n && sdaOutLow != sdaPrev && sclLine) sdaViol++;
    sdaPrev = sdaOutLow;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byte7(logic [6:0] a, logic rw);
    return {a, rw};
  endfunction
  function automatic logic [7:0] hdr10(logic [9:0] a);
    return {5'b11110, a[9:8], 1'b0};
  endfunction
  function automatic logic ack7(logic [6:0] own, logic [7:0] b);
    return (b[7:1] == own) && !b[0];
  endfunction

  task automatic quarter(); repeat (Q) @(negedge clk); endtask
  task automatic waitHigh(); while (!sclLine) @(negedge clk); endtask
  task automatic waitClk(int n); repeat (n) @(negedge clk); endtask

  task automatic regRead(logic [AW-1:0] a, output int d);
    regAddr = a; regRd = 1'b1;
    #1 d = int'(regRdata);
    @(negedge clk) regRd = 1'b0;
  endtask
  task automatic regWrite(logic [AW-1:0] a, int d);
    regAddr = a; regWdata = DW'(d); regWr = 1'b1;
    @(negedge clk) regWr = 1'b0;
  endtask

  task automatic sendBit(logic b);
    sdaDrv = b; quarter(); sclDrv = 1'b1; waitHigh(); quarter(); quarter();
    sclDrv = 1'b0; quarter();
  endtask
  task automatic sendBits8(logic [7:0] b);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
  endtask
  task automatic ackBit(output logic ackd);
    sdaDrv = 1'b1; quarter(); sclDrv = 1'b1; waitHigh(); quarter();
    ackd = (sdaLine == 1'b0); quarter(); sclDrv = 1'b0; quarter();
  endtask
  task automatic sendByte(logic [7:0] b, output logic ackd);
    sendBits8(b); ackBit(ackd);
  endtask
  task automatic startCond();
    sdaDrv = 1'b0; quarter(); sclDrv = 1'b0; quarter();
  endtask
  task automatic repStart();
    sdaDrv = 1'b1; quarter(); sclDrv = 1'b1; waitHigh(); quarter();
    sdaDrv = 1'b0; quarter(); sclDrv = 1'b0; quarter();
  endtask
  task automatic stopCond();
    sdaDrv = 1'b0; quarter(); sclDrv = 1'b1; waitHigh(); quarter();
    sdaDrv = 1'b1; quarter();
  endtask
  task automatic clearHit();
    int d;
    regRead(A_ST1, d); regRead(A_ST2, d); waitClk(3);
  endtask
  task automatic clearStop();
    int d;
    regRead(A_ST1, d); regWrite(A_CTRL, d & 0); 
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, seed;
    logic ack;
    logic [6:0] own7;
    logic [7:0] b1, b2, ab;
    seed = int'($urandom(32'd4242));
    waitClk(4); rst_n = 1'b1; waitClk(2);

    // R1 reset state
    regRead(A_ST1, d); chk("R1 status1 after reset", d, 0);
    regRead(A_CTRL, d); chk("R1 control after reset", d, 0);
    regRead(A_OWN, d); chk("R1 own address after reset", d, 0);
    chk("R1 scl released", int'(sclOutLow), 0);
    chk("R1 sda released", int'(sdaOutLow), 0);

    // R11 register readback
    regWrite(A_OWN, 'h3C5); regRead(A_OWN, d); chk("R11 own readback", d, 'h3C5);
    regWrite(A_CTRL, 3); regRead(A_CTRL, d); chk("R11 control readback", d, 3);

    // R12 disabled target ignores traffic
    own7 = 7'h52;
    regWrite(A_OWN, int'(own7)); regWrite(A_CTRL, 0);
    startCond(); sendByte(byte7(own7, 1'b0), ack);
    chk("R12 no ack when disabled", int'(ack), 0);
    regRead(A_ST2, d); chk("R11 bus busy between start and stop", d, 1);
    stopCond(); regRead(A_ST1, d); chk("R12 no flags when disabled", d, 0);

    // R2, R3 address match, stretch, strict clear
    regWrite(A_CTRL, 1);
    startCond(); sendByte(byte7(own7, 1'b0), ack);
    chk("R2 address ack", int'(ack), 1);
    waitClk(4); chk("R2 scl held after match", int'(sclOutLow), 1);
    regRead(A_ST2, d); waitClk(3);
    chk("R3 status2 alone keeps stretch", int'(sclOutLow), 1);
    regRead(A_ST1, d); chk("R2 address flag set", d, 1);
    regRead(A_DATA, d); regRead(A_ST2, d); waitClk(3);
    chk("R3 interleaved access keeps stretch", int'(sclOutLow), 1);
    clearHit();
    chk("R3 stretch released after sequence", int'(sclOutLow), 0);
    regRead(A_ST1, d); chk("R3 address flag cleared", d, 0);

    // R4, R5 data and back-pressure
    b1 = 8'hA7; b2 = 8'h3C;
    sendByte(b1, ack); chk("R4 data ack", int'(ack), 1);
    regRead(A_ST1, d); chk("R4 buffer full set", d, 2);
    sendBits8(b2); waitClk(3);
    chk("R5 scl held with buffer full", int'(sclOutLow), 1);
    chk("R5 no ack while buffer full", int'(sdaOutLow), 0);
    regRead(A_DATA, d); chk("R5 first byte kept", d, int'(b1));
    waitClk(3);
    chk("R5 scl released after read", int'(sclOutLow), 0);
    chk("R5 ack driven after read", int'(sdaOutLow), 1);
    ackBit(ack); chk("R5 ack seen by controller", int'(ack), 1);
    regRead(A_DATA, d); chk("R5 second byte loaded", d, int'(b2));
    regRead(A_ST1, d); chk("R4 buffer full cleared by read", d, 0);

    // R6 stop flag, strict clear
    stopCond(); regRead(A_ST1, d); chk("R6 stop flag set", d, 4);
    regRead(A_DATA, d); regWrite(A_CTRL, 1);
    regRead(A_ST1, d); chk("R6 interleaved access keeps stop", d, 4);
    regWrite(A_CTRL, 1);
    regRead(A_ST1, d); chk("R6 stop cleared by sequence", d, 0);

    // R8 direction bit set, and idle until next START
    startCond(); sendByte(byte7(own7, 1'b1), ack);
    chk("R8 read direction not acked", int'(ack), 0);
    sendByte(byte7(own7, 1'b0), ack);
    chk("R8 ignored until next start", int'(ack), 0);
    stopCond(); regRead(A_ST1, d); chk("R8 no flags after mismatch", d, 0);

    // R9 repeated start
    startCond(); sendByte(byte7(own7, 1'b0), ack); clearHit();
    sendByte(8'h11, ack); regRead(A_DATA, d); chk("R4 byte before restart", d, 'h11);
    repStart(); sendByte(byte7(own7, 1'b0), ack);
    chk("R9 address acked after restart", int'(ack), 1);
    regRead(A_ST1, d); chk("R9 no stop flag on restart", d, 1);
    regRead(A_ST2, d); waitClk(3);
    stopCond(); regRead(A_ST1, d); regWrite(A_CTRL, 1);

    // R7 10-bit mode
    regWrite(A_OWN, 'h2A5); regWrite(A_CTRL, 3);
    startCond(); sendByte(hdr10(10'h2A5), ack); chk("R7 header ack", int'(ack), 1);
    regRead(A_ST1, d); chk("R7 no flag after header only", d, 0);
    sendByte(8'hA5, ack); chk("R7 low byte ack", int'(ack), 1);
    regRead(A_ST1, d); chk("R7 address flag after both bytes", d, 1);
    regRead(A_ST2, d); waitClk(3);
    sendByte(8'h5E, ack); regRead(A_DATA, d); chk("R7 data in 10-bit mode", d, 'h5E);
    stopCond(); clearStop(); regWrite(A_CTRL, 3);
    startCond(); sendByte(8'hF2, ack); chk("R8 wrong header nack", int'(ack), 0);
    stopCond();
    startCond(); sendByte(8'hF5, ack); chk("R8 header with read direction nack", int'(ack), 0);
    stopCond();
    startCond(); sendByte(hdr10(10'h2A5), ack); sendByte(8'hA4, ack);
    chk("R8 wrong low byte nack", int'(ack), 0);
    stopCond(); regRead(A_ST1, d); chk("R8 no flags after 10-bit mismatch", d, 0);

    // random 7-bit transfers
    regWrite(A_CTRL, 1);
    for (int t = 0; t < 8; t++) begin
      logic expAck;
      int n;
      own7 = 7'($urandom);
      regWrite(A_OWN, int'(own7));
      ab = ($urandom % 4 != 0) ? byte7(own7, 1'b0) : 8'($urandom);
      expAck = ack7(own7, ab);
      startCond(); sendByte(ab, ack);
      chk("R2 random address ack", int'(ack), int'(expAck));
      if (expAck) begin
        clearHit();
        n = 1 + int'($urandom % 3);
        for (int k = 0; k < n; k++) begin
          logic [7:0] db;
          db = 8'($urandom);
          sendByte(db, ack); chk("R4 random data ack", int'(ack), 1);
          regRead(A_DATA, d); chk("R4 random data value", d, int'(db));
        end
      end
      stopCond();
      regRead(A_ST1, d); chk("R6 random stop flag", d, expAck ? 4 : 0);
      regWrite(A_CTRL, 1);
      regRead(A_ST1, d); chk("R6 random stop cleared", d, 0);
    end

    chk("R10 sda changed only with scl low", sdaViol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule